// File: doc/BRIEF.md
# PLL Control Shadow Register Unit

This block sits on a simple register bus and controls the PLL in a microcontroller's clock system. Software writes the PLL enable and connect bits and the multiplier and divider fields into pending copies. The PLL outputs do not move when those writes land. They change only when software gives an unlock sequence on the feed address. On that sequence every pending field is copied into the active copy in the same clock cycle.

A read-only status word reports the active values and a synchronized lock flag, so software can see what is in force. The connect output is asserted only when both the active enable bit and the active connect bit are set. Otherwise the oscillator clock stays selected downstream. The block never checks lock before it connects. It also never disconnects the PLL on its own when lock drops.

The bus does one access per cycle: `bus_sel` high marks an access and `bus_wr` selects a write. Writes are captured on the rising clock edge. Read data is combinational from the current register state.

Top module: `pll_shadow_regs`

## Requirements
- R1: After reset, both pending copies, the active copy and all four PLL outputs are zero, and the status word reads 0x0000.
- R2: A write to the control word at offset 0x0 updates the pending enable (data bit 0) and pending connect (data bit 1). A write to the config word at offset 0x4 updates the pending multiplier (data bits 4:0) and pending divider (data bits 6:5). Reads of these two words return the pending values.
- R3: Writes to the control or config word leave the active values, the PLL outputs and the status word unchanged until a valid feed.
- R4: A valid feed is a write of 0xAA to offset 0xC, then a write of 0x55 to offset 0xC as the next bus access. Idle cycles between the two writes are allowed. A repeated 0xAA write keeps the sequence armed.
- R5: Any other bus access between the 0xAA write and the 0x55 write cancels the sequence. This includes reads and writes to other offsets. A 0x55 write with no armed sequence does nothing.
- R6: When the 0x55 write completes a valid feed, enable, connect, multiplier and divider are all copied from pending to active on that same clock edge.
- R7: The status word at offset 0x8 has this layout: active multiplier in bits 4:0, active divider in bits 6:5, active enable in bit 8, active connect bit in bit 9, synchronized lock in bit 10. All other bits read 0. Writes to offset 0x8 are ignored.
- R8: `pll_conn_o` is high only when both the active enable bit and the active connect bit are 1.
- R9: The lock input reaches status bit 10 through two flip-flops. It reads 0 after the first rising edge that samples lock high, and 1 after the second.
- R10: A drop of lock does not change `pll_en_o` or `pll_conn_o`.
- R11: Reserved bits read as 0 and writes to them are ignored: control bits 7:2, config bit 7, the feed word at 0xC, and any other offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset, released synchronously upstream |
| bus_sel | input | 1 | Bus access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 16 | Read data |
| pll_lock_i | input | 1 | Lock indication from the PLL, asynchronous |
| pll_en_o | output | 1 | Active PLL enable |
| pll_conn_o | output | 1 | Select the PLL as clock source |
| pll_m_o | output | 5 | Active multiplier field |
| pll_p_o | output | 2 | Active divider field |

## Verification
Some rules are checked on every cycle:
- The active copy holds still on any cycle with no commit.
- A commit loads exactly the pending values seen on the cycle before.
- The feed sequence arms only after an 0xAA feed write, and any other access disarms it.
- The status and feed reads keep their unused bits at zero.
- Lock rises at the output only after the preceding stage was high.

The bench scenarios cover the rest:
- The ordering cases: interrupted, reversed and repeated key writes.
- Pending read-back against the active status.
- The exact edge at which lock appears.
- The PLL staying connected after lock is lost.

// File: rtl/pll_shadow_pkg.sv
package pll_shadow_pkg;

  localparam int ADDR_W  = 4;
  localparam int WDATA_W = 8;
  localparam int RDATA_W = 16;
  localparam int MUL_W   = 5;
  localparam int DIV_W   = 2;
  localparam int SYNC_N  = 2;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_CFG  = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_STAT = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_KEY  = 4'hC;

  localparam logic [WDATA_W-1:0] KEY_FIRST  = 8'hAA;
  localparam logic [WDATA_W-1:0] KEY_SECOND = 8'h55;

  // status word layout
  localparam int ST_MUL_LSB = 0;
  localparam int ST_DIV_LSB = 5;
  localparam int ST_EN_BIT  = 8;
  localparam int ST_CON_BIT = 9;
  localparam int ST_LCK_BIT = 10;

  typedef struct packed {
    logic             en;
    logic             conn;
    logic [MUL_W-1:0] mul;
    logic [DIV_W-1:0] div;
  } pll_set_t;

  typedef enum logic {
    KEY_IDLE  = 1'b0,
    KEY_ARMED = 1'b1
  } key_state_t;

endpackage

// File: rtl/pll_feed_detect.sv
module pll_feed_detect
  import pll_shadow_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_i,
  input  logic               wr_i,
  input  logic               key_sel_i,
  input  logic [WDATA_W-1:0] wdata_i,
  output logic               commit_o
);

  key_state_t state_q, state_d;
  logic       key_wr;
  logic       first_hit;
  logic       second_hit;

  assign key_wr     = acc_i && wr_i && key_sel_i;
  assign first_hit  = key_wr && (wdata_i == KEY_FIRST);
  assign second_hit = key_wr && (wdata_i == KEY_SECOND);

  always_comb begin
    state_d  = state_q;
    commit_o = 1'b0;
    if (acc_i) begin
      if (first_hit) begin
        state_d = KEY_ARMED;
      end else if ((state_q == KEY_ARMED) && second_hit) begin
        state_d  = KEY_IDLE;
        commit_o = 1'b1;
      end else begin
        state_d = KEY_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KEY_IDLE;
    else        state_q <= state_d;
  end

  // R4
  arm_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == KEY_ARMED) && $changed(state_q) |-> $past(first_hit));

  // R5
  cancel_on_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == KEY_ARMED && acc_i && !key_wr) |=> (state_q == KEY_IDLE));

endmodule

// File: rtl/pll_shadow_bank.sv
module pll_shadow_bank
  import pll_shadow_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ctrl_we_i,
  input  logic [1:0]             ctrl_bits_i,
  input  logic                   cfg_we_i,
  input  logic [MUL_W+DIV_W-1:0] cfg_bits_i,
  input  logic                   commit_i,
  output pll_set_t               pend_o,
  output pll_set_t               act_o
);

  pll_set_t pend_q, pend_d;
  pll_set_t act_q, act_d;

  always_comb begin
    pend_d = pend_q;
    if (ctrl_we_i) begin
      pend_d.en   = ctrl_bits_i[0];
      pend_d.conn = ctrl_bits_i[1];
    end
    if (cfg_we_i) begin
      pend_d.mul = cfg_bits_i[MUL_W-1:0];
      pend_d.div = cfg_bits_i[MUL_W+DIV_W-1:MUL_W];
    end
  end

  always_comb begin
    act_d = act_q;
    if (commit_i) act_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        act_q <= '0;
    else if (commit_i) act_q <= act_d;
  end

  assign pend_o = pend_q;
  assign act_o  = act_q;

  // R3
  hold_without_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(act_q));

  // R6
  commit_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |=> (act_q == $past(pend_q)));

endmodule

// File: rtl/pll_lock_sync.sv
module pll_lock_sync
  import pll_shadow_pkg::*;
#(
  parameter int STAGES = SYNC_N
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_i,
  output logic lock_o
);

  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= 1'b0;
    else        stage_q[0] <= lock_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= 1'b0;
      else        stage_q[g] <= stage_q[g-1];
    end
  end

  assign lock_o = stage_q[STAGES-1];

  // R9
  lock_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> $past(stage_q[STAGES-2]));

endmodule

// File: rtl/pll_shadow_regs.sv
module pll_shadow_regs
  import pll_shadow_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [WDATA_W-1:0] bus_wdata,
  output logic [RDATA_W-1:0] bus_rdata,
  input  logic               pll_lock_i,
  output logic               pll_en_o,
  output logic               pll_conn_o,
  output logic [MUL_W-1:0]   pll_m_o,
  output logic [DIV_W-1:0]   pll_p_o
);

  logic     hit_ctrl, hit_cfg, hit_stat, hit_key;
  logic     commit;
  logic     lock_s;
  pll_set_t pend, act;

  assign hit_ctrl = (bus_addr == OFS_CTRL);
  assign hit_cfg  = (bus_addr == OFS_CFG);
  assign hit_stat = (bus_addr == OFS_STAT);
  assign hit_key  = (bus_addr == OFS_KEY);

  pll_feed_detect u_feed (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_i     (bus_sel),
    .wr_i      (bus_wr),
    .key_sel_i (hit_key),
    .wdata_i   (bus_wdata),
    .commit_o  (commit)
  );

  pll_shadow_bank u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_we_i   (bus_sel && bus_wr && hit_ctrl),
    .ctrl_bits_i (bus_wdata[1:0]),
    .cfg_we_i    (bus_sel && bus_wr && hit_cfg),
    .cfg_bits_i  (bus_wdata[MUL_W+DIV_W-1:0]),
    .commit_i    (commit),
    .pend_o      (pend),
    .act_o       (act)
  );

  pll_lock_sync #(.STAGES(SYNC_N)) u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .lock_i (pll_lock_i),
    .lock_o (lock_s)
  );

  always_comb begin
    bus_rdata = '0;
    if (hit_ctrl) begin
      bus_rdata[0] = pend.en;
      bus_rdata[1] = pend.conn;
    end else if (hit_cfg) begin
      bus_rdata[MUL_W-1:0]           = pend.mul;
      bus_rdata[MUL_W+DIV_W-1:MUL_W] = pend.div;
    end else if (hit_stat) begin
      bus_rdata[ST_MUL_LSB +: MUL_W] = act.mul;
      bus_rdata[ST_DIV_LSB +: DIV_W] = act.div;
      bus_rdata[ST_EN_BIT]           = act.en;
      bus_rdata[ST_CON_BIT]          = act.conn;
      bus_rdata[ST_LCK_BIT]          = lock_s;
    end
  end

  assign pll_en_o   = act.en;
  assign pll_conn_o = act.en & act.conn;
  assign pll_m_o    = act.mul;
  assign pll_p_o    = act.div;

  // R7
  stat_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_stat |-> (bus_rdata[RDATA_W-1:ST_LCK_BIT+1] == '0 && bus_rdata[7] == 1'b0));

  // R11
  key_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_key |-> (bus_rdata == '0));

  // R10
  no_auto_disconnect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lock_s) && !$past(commit)) |-> $stable(pll_conn_o));

endmodule

// File: tb/pll_shadow_regs_tb.sv
module pll_shadow_regs_tb;
  import pll_shadow_pkg::*;

  logic               clk;
  logic               rst_n;
  logic               bus_sel, bus_wr;
  logic [ADDR_W-1:0]  bus_addr;
  logic [WDATA_W-1:0] bus_wdata;
  logic [RDATA_W-1:0] bus_rdata;
  logic               pll_lock_i;
  logic               pll_en_o, pll_conn_o;
  logic [MUL_W-1:0]   pll_m_o;
  logic [DIV_W-1:0]   pll_p_o;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 0;

  pll_shadow_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pll_lock_i(pll_lock_i), .pll_en_o(pll_en_o), .pll_conn_o(pll_conn_o),
    .pll_m_o(pll_m_o), .pll_p_o(pll_p_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic                wr;
    logic [ADDR_W-1:0]   addr;
    logic [WDATA_W-1:0]  data;
    logic [RDATA_W-1:0]  exp;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'h0, 8'h00, 16'h0000}, // R1 pending ctrl at reset
    '{1'b1, 4'h0, 8'h03, 16'h0000},
    '{1'b1, 4'h4, 8'hD3, 16'h0000},
    '{1'b0, 4'h0, 8'h00, 16'h0003}, // R2
    '{1'b0, 4'h4, 8'h00, 16'h0053}, // R2 R11 bit7 dropped
    '{1'b0, 4'h8, 8'h00, 16'h0000}, // R3 no feed yet
    '{1'b1, 4'hC, 8'hAA, 16'h0000},
    '{1'b1, 4'hC, 8'h55, 16'h0000},
    '{1'b0, 4'h8, 8'h00, 16'h0353}, // R4 R6 R7
    '{1'b1, 4'h0, 8'hFE, 16'h0000},
    '{1'b0, 4'h0, 8'h00, 16'h0002}, // R11 ctrl reserved ignored
    '{1'b1, 4'hC, 8'hAA, 16'h0000},
    '{1'b0, 4'h0, 8'h00, 16'h0002}, // read cancels
    '{1'b1, 4'hC, 8'h55, 16'h0000},
    '{1'b0, 4'h8, 8'h00, 16'h0353}, // R5 read interrupt
    '{1'b1, 4'hC, 8'h55, 16'h0000},
    '{1'b1, 4'hC, 8'hAA, 16'h0000},
    '{1'b0, 4'h8, 8'h00, 16'h0353}, // R5 reversed order
    '{1'b1, 4'hC, 8'hAA, 16'h0000},
    '{1'b1, 4'hC, 8'hAA, 16'h0000},
    '{1'b1, 4'hC, 8'h55, 16'h0000},
    '{1'b0, 4'h8, 8'h00, 16'h0253}, // R4 repeated key
    '{1'b1, 4'hC, 8'hAA, 16'h0000},
    '{1'b1, 4'h4, 8'h00, 16'h0000},
    '{1'b1, 4'hC, 8'h55, 16'h0000},
    '{1'b0, 4'h8, 8'h00, 16'h0253}, // R5 write interrupt
    '{1'b0, 4'h4, 8'h00, 16'h0000}, // R2
    '{1'b0, 4'hC, 8'h00, 16'h0000}, // R11 feed reads 0
    '{1'b0, 4'h2, 8'h00, 16'h0000}  // R11 unmapped
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [WDATA_W-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [RDATA_W-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [RDATA_W-1:0] rd;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; pll_lock_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state at the pins and in status
    #1;
    check("R1 en", pll_en_o, 0);
    check("R1 conn", pll_conn_o, 0);
    check("R1 m/p", {pll_m_o, pll_p_o}, 0);
    bus_read(OFS_STAT, rd);
    check("R1 status", rd, 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) begin
        bus_write(VEC[i].addr, VEC[i].data);
      end else begin
        bus_read(VEC[i].addr, rd);
        check($sformatf("R2/R3/R4/R5/R6/R7/R11 vec %0d", i), rd, VEC[i].exp);
      end
    end

    // R8 active en=0 conn=1 keeps oscillator
    check("R8 conn needs en", pll_conn_o, 0);
    check("R3 en pin", pll_en_o, 0);

    // R6 commit updates pins together
    bus_write(OFS_CTRL, 8'h03);
    bus_write(OFS_CFG, 8'h2A);
    check("R3 pins before feed", {pll_en_o, pll_conn_o, pll_m_o, pll_p_o}, {2'b00, 5'h13, 2'h2});
    bus_write(OFS_KEY, KEY_FIRST);
    bus_write(OFS_KEY, KEY_SECOND);
    check("R6 pins after feed", {pll_en_o, pll_conn_o, pll_m_o, pll_p_o}, {2'b11, 5'h0A, 2'h1});
    check("R8 connected", pll_conn_o, 1);

    // R7 write to status ignored
    bus_write(OFS_STAT, 8'hFF);
    bus_read(OFS_STAT, rd);
    check("R7 status write ignored", rd, 16'h032A);

    // R9 lock timing, R10 no auto disconnect
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = OFS_STAT; pll_lock_i = 1'b1;
    @(posedge clk); #1;
    check("R9 lock after one edge", bus_rdata[ST_LCK_BIT], 0);
    @(posedge clk); #1;
    check("R9 lock after two edges", bus_rdata[ST_LCK_BIT], 1);
    @(negedge clk) pll_lock_i = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    check("R9 lock dropped", bus_rdata[ST_LCK_BIT], 0);
    check("R10 still connected", {pll_en_o, pll_conn_o}, 2'b11);
    @(negedge clk) bus_sel = 1'b0;

    finish_run();
  end

endmodule